// File: doc/BRIEF.md
# Time-Sliced Shared Framebuffer Controller

This block keeps a one-bit-per-pixel picture (640 by 480 by default) in on-chip RAM and lets two users share that single memory port without any arbitration. The memory clock runs at twice the host bus rate. A phase flag splits every host bus cycle into two memory slots. The even slot belongs to the raster scanout and the odd slot belongs to the host. Neither side can delay the other, so host access latency is fixed and the display never misses a fetch.

The host side is a 32-bit bus. An access carries its address in one bus cycle and, for a write, its data and four byte strobes in the next. The block answers only inside a parameterised address window. The scanout side takes the pixel counters of an external sync generator. It prefetches the next 32-pixel word during an even slot, shifts pixels out most significant bit first, and outputs black outside the visible area.

The host protocol is a state machine with the states HS_IDLE, HS_WDATA, HS_WCOMMIT, HS_RREAD and HS_ACK. It changes state only at the close of an odd slot. The transitions are as follows:
- HS_IDLE goes to HS_WDATA on an in-window write, and to HS_RREAD on an in-window read.
- HS_WDATA goes to HS_WCOMMIT.
- HS_WCOMMIT goes to HS_ACK.
- HS_RREAD goes to HS_ACK.
- HS_ACK goes back to HS_IDLE.
- Reset returns the machine to HS_IDLE from any state.

Top module: `fb_slot_ctrl`

## Requirements
- R1: Synchronous reset sets the slot phase to even, clears the pixel shift register (pixel output 0, acknowledge low) and drops any host access in progress, so no acknowledge and no memory change follow it.
- R2: A host access whose address lies outside [BASE, BASE + 4*WORDS) gets no acknowledge and changes no framebuffer word.
- R3: For a write, the address is taken in bus cycle 0 and the data with strobes in bus cycle 1. The word is committed in the odd slot of bus cycle 2, and the acknowledge is high for exactly bus cycle 3 (two memory clocks).
- R4: Write strobe bit b (b = 0..3) enables data byte bits 8b+7..8b; bytes with a clear strobe keep their stored value.
- R5: For a read taken in bus cycle 0, the word is read in the odd slot of bus cycle 1, and the acknowledge and read data are present for exactly bus cycle 2.
- R6: The word index is (address - BASE) >> 2; the two lowest address bits are ignored.
- R7: For a visible pixel (x, y), the pixel output one memory clock after the counters show (x, y) equals bit 31 - (x mod 32) of word y*(H_ACT/32) + x/32. Bit 31 is the leftmost pixel.
- R8: When the counters are outside the visible area, the pixel output is 0 on the following clock.
- R9: Display fetches use only even slots and host accesses use only odd slots. Host reads during active scanout keep their R5 timing, and scanout stays correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, twice the host bus rate |
| rst | input | 1 | Synchronous reset, active high |
| hb_sel | input | 1 | Host address strobe, valid in the first bus cycle |
| hb_we | input | 1 | Host write (1) or read (0), valid with hb_sel |
| hb_addr | input | 32 | Host byte address |
| hb_wdata | input | 32 | Host write data, second bus cycle |
| hb_be | input | 4 | Host byte strobes, second bus cycle |
| hb_rdata | output | 32 | Host read data |
| hb_ack | output | 1 | Access complete, one bus cycle |
| pix_ce | input | 1 | Pixel clock enable |
| pix_x | input | XW | Horizontal pixel counter |
| pix_y | input | YW | Vertical line counter |
| pix_out | output | 1 | Serial pixel, 1 = white |

## Verification
Host accesses and display fetches fall into the same bus cycle all the time: one uses the even slot and the other uses the odd slot. The bench provokes this by running a free-running raster while it walks a table of host transfers. During one full checked frame it reads back every word. Each read's acknowledge position and data are judged against the fixed latency. Every scanned pixel is compared with a shadow copy of the picture, and blanking pixels are compared with black.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    localparam int PIX_PER_WORD = 32;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_WDATA,
        HS_WCOMMIT,
        HS_RREAD,
        HS_ACK
    } host_state_t;
endpackage

// File: rtl/fbs_host_fsm.sv
module fbs_host_fsm
    import fbs_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h00C0_0000,
    parameter int          WORDS = 9600,
    parameter int          AW    = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_odd,
    input  logic          hb_sel,
    input  logic          hb_we,
    input  logic [31:0]   hb_addr,
    input  logic [31:0]   hb_wdata,
    input  logic [3:0]    hb_be,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] word,
    output logic [31:0]   wdata,
    output logic [3:0]    be,
    output logic          hb_ack
);
    localparam logic [31:0] WIN_BYTES = 32'(WORDS * 4);

    host_state_t state, nstate;
    logic [31:0] off;
    logic        hit;

    assign off = hb_addr - BASE;
    assign hit = (hb_addr >= BASE) && (off < WIN_BYTES);

    // next-state decision, moves only at the close of an odd slot
    always_comb begin
        nstate = state;
        if (slot_odd) begin
            unique case (state)
                HS_IDLE:    if (hb_sel && hit) nstate = hb_we ? HS_WDATA : HS_RREAD;
                HS_WDATA:   nstate = HS_WCOMMIT;
                HS_WCOMMIT: nstate = HS_ACK;
                HS_RREAD:   nstate = HS_ACK;
                HS_ACK:     nstate = HS_IDLE;
                default:    nstate = HS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= nstate;
    end

    // captured request fields
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            wdata <= '0;
            be    <= '0;
        end else if (slot_odd) begin
            if (state == HS_IDLE && hb_sel && hit) word <= off[AW+1:2];
            if (state == HS_WDATA) begin
                wdata <= hb_wdata;
                be    <= hb_be;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en  = slot_odd && (state == HS_WCOMMIT);
        rd_en  = slot_odd && (state == HS_RREAD);
        hb_ack = (state == HS_ACK);
    end

    // R3 / R5: acknowledge lasts exactly one bus cycle (two memory clocks)
    a_r3_ack_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_ack) |=> hb_ack);
    a_r3_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (hb_ack && $past(hb_ack)) |=> !hb_ack);
endmodule

// File: rtl/fbs_scanout.sv
module fbs_scanout
    import fbs_pkg::*;
#(
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    parameter int XW    = 11,
    parameter int YW    = 10,
    parameter int AW    = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_odd,
    input  logic          pix_ce,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic [31:0]   fetch_data,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_word,
    output logic          pix_out
);
    localparam int WPL = H_ACT / PIX_PER_WORD;
    localparam int CW  = XW - 5;

    logic          active, load, last_col, last_row, pf_valid;
    logic [CW-1:0] col;
    logic [AW-1:0] nxt;
    logic [31:0]   sr;

    assign active    = (pix_x < XW'(H_ACT)) && (pix_y < YW'(V_ACT));
    assign col       = pix_x[XW-1:5];
    assign load      = pix_ce && active && (pix_x[4:0] == 5'd0);
    assign last_col  = (col == CW'(WPL - 1));
    assign last_row  = (pix_y == YW'(V_ACT - 1));
    assign nxt       = last_col ? (last_row ? '0 : AW'((32'(pix_y) + 1) * WPL))
                                : AW'(32'(pix_y) * WPL + 32'(col) + 1);
    assign fetch_req = !pf_valid && !slot_odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid   <= 1'b0;
            fetch_word <= '0;
            sr         <= '0;
            pix_out    <= 1'b0;
        end else begin
            if (fetch_req) pf_valid <= 1'b1;
            if (load) begin
                pf_valid   <= 1'b0;
                fetch_word <= nxt;
            end
            if (pix_ce) begin
                if (!active) begin
                    pix_out <= 1'b0;
                end else if (load) begin
                    pix_out <= fetch_data[31];
                    sr      <= {fetch_data[30:0], 1'b0};
                end else begin
                    pix_out <= sr[31];
                    sr      <= {sr[30:0], 1'b0};
                end
            end
        end
    end

    // R8: blanking forces black on the next clock
    a_r8_black: assert property (@(posedge clk) disable iff (rst)
        (pix_ce && !active) |=> !pix_out);
endmodule

// File: rtl/fbs_bank_ram.sv
module fbs_bank_ram #(
    parameter int WORDS = 9600,
    parameter int LANES = 4,
    parameter int AW    = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_odd,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] host_word,
    input  logic [31:0]   wdata,
    input  logic [3:0]    be,
    input  logic          fetch_en,
    input  logic [AW-1:0] fetch_word,
    output logic [31:0]   rdata,
    output logic [31:0]   fetch_data
);
    localparam int LB   = $clog2(LANES);
    localparam int ROWS = (WORDS + LANES - 1) / LANES;

    logic [32*LANES-1:0] mem [ROWS];
    logic [AW-1:0]       word;
    logic [AW-LB-1:0]    row;
    logic [LB-1:0]       lane;
    logic [32*LANES-1:0] row_q;
    logic [31:0]         lane_q;

    // one address port, owner chosen by slot phase
    assign word   = slot_odd ? host_word : fetch_word;
    assign row    = word[AW-1:LB];
    assign lane   = word[LB-1:0];
    assign row_q  = mem[row];
    assign lane_q = row_q[32*lane +: 32];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_en && lane == LB'(l) && be[b])
                    mem[row][(l*4+b)*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            fetch_data <= '0;
        end else begin
            if (rd_en)    rdata      <= lane_q;
            if (fetch_en) fetch_data <= lane_q;
        end
    end

    // R9: display and host never claim the port in the same memory cycle
    a_r9_one_user: assert property (@(posedge clk) disable iff (rst)
        !(fetch_en && (wr_en || rd_en)));
endmodule

// File: rtl/fb_slot_ctrl.sv
module fb_slot_ctrl
    import fbs_pkg::*;
#(
    parameter int          H_ACT = 640,
    parameter int          V_ACT = 480,
    parameter int          XW    = 11,
    parameter int          YW    = 10,
    parameter int          LANES = 4,
    parameter logic [31:0] BASE  = 32'h00C0_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hb_sel,
    input  logic          hb_we,
    input  logic [31:0]   hb_addr,
    input  logic [31:0]   hb_wdata,
    input  logic [3:0]    hb_be,
    output logic [31:0]   hb_rdata,
    output logic          hb_ack,
    input  logic          pix_ce,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    output logic          pix_out
);
    localparam int WORDS = H_ACT * V_ACT / PIX_PER_WORD;
    localparam int AW    = $clog2(WORDS);

    logic          odd;
    logic          wr_en, rd_en, fetch_req;
    logic [AW-1:0] h_word, f_word;
    logic [31:0]   h_wdata, f_data;
    logic [3:0]    h_be;

    always_ff @(posedge clk) begin
        if (rst) odd <= 1'b0;
        else     odd <= !odd;
    end

    fbs_host_fsm #(.BASE(BASE), .WORDS(WORDS), .AW(AW)) u_host (
        .clk(clk), .rst(rst), .slot_odd(odd),
        .hb_sel(hb_sel), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_be(hb_be),
        .wr_en(wr_en), .rd_en(rd_en), .word(h_word),
        .wdata(h_wdata), .be(h_be), .hb_ack(hb_ack)
    );

    fbs_scanout #(.H_ACT(H_ACT), .V_ACT(V_ACT), .XW(XW), .YW(YW), .AW(AW)) u_scan (
        .clk(clk), .rst(rst), .slot_odd(odd),
        .pix_ce(pix_ce), .pix_x(pix_x), .pix_y(pix_y),
        .fetch_data(f_data), .fetch_req(fetch_req),
        .fetch_word(f_word), .pix_out(pix_out)
    );

    fbs_bank_ram #(.WORDS(WORDS), .LANES(LANES), .AW(AW)) u_ram (
        .clk(clk), .rst(rst), .slot_odd(odd),
        .wr_en(wr_en), .rd_en(rd_en), .host_word(h_word),
        .wdata(h_wdata), .be(h_be),
        .fetch_en(fetch_req), .fetch_word(f_word),
        .rdata(hb_rdata), .fetch_data(f_data)
    );

    // R1: slot phase alternates strictly after reset
    a_r1_even_to_odd: assert property (@(posedge clk) disable iff (rst)
        !odd |=> odd);
    a_r1_odd_to_even: assert property (@(posedge clk) disable iff (rst)
        odd |=> !odd);
endmodule

// File: tb/sim_fb_slot_ctrl.sv
`timescale 1ns/1ps
module sim_fb_slot_ctrl;
    localparam int          H = 64;
    localparam int          V = 4;
    localparam int          HT = 80;
    localparam int          VT = 5;
    localparam int          NW = H * V / 32;
    localparam logic [31:0] BASE = 32'h0040_0000;

    typedef struct packed {
        logic        we;
        logic [31:0] off;
        logic [31:0] data;
        logic [3:0]  be;
        logic [2:0]  ack_at;
        logic [31:0] rexp;
    } vec_t;

    // ack_at: bus cycle index of acknowledge, 0 = none expected
    localparam vec_t VECS [16] = '{
        '{1'b1, 32'h00, 32'hA5A5_0F0F, 4'hF, 3'd3, 32'h0},
        '{1'b0, 32'h00, 32'h0,         4'h0, 3'd2, 32'hA5A5_0F0F},
        '{1'b1, 32'h1C, 32'h1234_5678, 4'hF, 3'd3, 32'h0},
        '{1'b0, 32'h1C, 32'h0,         4'h0, 3'd2, 32'h1234_5678},
        '{1'b1, 32'h1C, 32'hFFFF_FFFF, 4'h5, 3'd3, 32'h0},          // R4 bytes 0,2
        '{1'b0, 32'h1C, 32'h0,         4'h0, 3'd2, 32'h12FF_56FF},
        '{1'b1, 32'h06, 32'hDEAD_BEEF, 4'hF, 3'd3, 32'h0},          // R6 low bits
        '{1'b0, 32'h04, 32'h0,         4'h0, 3'd2, 32'hDEAD_BEEF},
        '{1'b1, 32'h20, 32'h0,         4'hF, 3'd0, 32'h0},
        '{1'b1, 32'hFFFF_FFFC, 32'h0,  4'hF, 3'd0, 32'h0},
        '{1'b0, 32'h20, 32'h0,         4'h0, 3'd0, 32'h0},
        '{1'b0, 32'h00, 32'h0,         4'h0, 3'd2, 32'hA5A5_0F0F},
        '{1'b0, 32'h1C, 32'h0,         4'h0, 3'd2, 32'h12FF_56FF},
        '{1'b1, 32'h08, 32'h0,         4'hF, 3'd3, 32'h0},
        '{1'b1, 32'h08, 32'h7700_0011, 4'h8, 3'd3, 32'h0},          // R4 top byte
        '{1'b0, 32'h0B, 32'h0,         4'h0, 3'd2, 32'h7700_0000}   // R6
    };

    logic        clk = 0, rst = 1;
    logic        hb_sel = 0, hb_we = 0, pix_ce = 1;
    logic [31:0] hb_addr = 0, hb_wdata = 0;
    logic [3:0]  hb_be = 0;
    logic [31:0] hb_rdata;
    logic        hb_ack, pix_out;
    logic [10:0] pix_x = 0;
    logic [9:0]  pix_y = 0;

    int nchk = 0, nerr = 0;
    bit done = 0, pix_chk = 0;
    int act_seen = 0, act_bad = 0, blk_seen = 0, blk_bad = 0;
    logic [31:0] shadow [NW];

    always #10 clk = ~clk;

    fb_slot_ctrl #(.H_ACT(H), .V_ACT(V), .XW(11), .YW(10), .LANES(4), .BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .hb_sel(hb_sel), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_be(hb_be), .hb_rdata(hb_rdata), .hb_ack(hb_ack),
        .pix_ce(pix_ce), .pix_x(pix_x), .pix_y(pix_y), .pix_out(pix_out)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hC3A5_0000 + 32'(i) * 32'h0001_1337;
    endfunction

    function automatic logic exp_pix(int x, int y);
        if (x >= H || y >= V) return 1'b0;
        return shadow[y * (H / 32) + x / 32][31 - (x % 32)];
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // free-running raster model; pixel output compared one clock later (R7, R8)
    initial begin
        int x = 0, y = 0;
        logic e = 0;
        bit was_act = 0, have = 0;
        forever begin
            @(negedge clk);
            if (have && pix_chk) begin
                if (was_act) begin act_seen++; if (pix_out !== e) act_bad++; end
                else         begin blk_seen++; if (pix_out !== e) blk_bad++; end
            end
            x++;
            if (x == HT) begin x = 0; y = (y + 1) % VT; end
            pix_x = 11'(x);
            pix_y = 10'(y);
            e = exp_pix(x, y);
            was_act = (x < H) && (y < V);
            have = 1;
        end
    end

    task automatic xfer(input logic we, input logic [31:0] addr, input logic [31:0] data,
                        input logic [3:0] be, output int ack_at, output int acks,
                        output logic [31:0] rd);
        ack_at = 0; acks = 0; rd = '0;
        hb_sel = 1; hb_we = we; hb_addr = addr; hb_wdata = '0; hb_be = '0;
        repeat (2) @(negedge clk);
        hb_sel = 0; hb_wdata = data; hb_be = be;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (hb_ack) begin
                acks++;
                if (ack_at == 0) begin ack_at = k; rd = hb_rdata; end
            end
            @(negedge clk);
            if (k == 1) begin hb_wdata = '0; hb_be = '0; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        int at, n;
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        check(hb_ack == 1'b0, "R1", "ack in reset", 32'(hb_ack), 32'h0);
        check(pix_out == 1'b0, "R1", "pixel in reset", 32'(pix_out), 32'h0);
        rst = 0;

        // table walk
        for (int i = 0; i < 16; i++) begin
            string tag;
            tag = (VECS[i].ack_at == 0) ? "R2" : (VECS[i].we ? "R3" : "R5");
            xfer(VECS[i].we, BASE + VECS[i].off, VECS[i].data, VECS[i].be, at, n, rd);
            check(at == int'(VECS[i].ack_at) && n == ((VECS[i].ack_at != 0) ? 1 : 0),
                  tag, $sformatf("vector %0d ack cycle/count", i),
                  32'(at * 16 + n), 32'(VECS[i].ack_at) * 16 + ((VECS[i].ack_at != 0) ? 1 : 0));
            if (!VECS[i].we && VECS[i].ack_at != 0)
                check(rd == VECS[i].rexp, "R5", $sformatf("vector %0d read data", i),
                      rd, VECS[i].rexp);
        end

        // picture load
        for (int i = 0; i < NW; i++) begin
            shadow[i] = pat(i);
            xfer(1'b1, BASE + 32'(i * 4), pat(i), 4'hF, at, n, rd);
        end

        // R1: reset in the data cycle of a write drops it
        hb_sel = 1; hb_we = 1; hb_addr = BASE + 32'h0C;
        repeat (2) @(negedge clk);
        hb_sel = 0; hb_wdata = 32'hFFFF_FFFF; hb_be = 4'hF; rst = 1;
        repeat (2) @(negedge clk);
        rst = 0; hb_wdata = 0; hb_be = 0;
        n = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); if (hb_ack) n++;
            @(negedge clk);
        end
        check(n == 0, "R1", "ack after reset-aborted write", 32'(n), 32'h0);
        xfer(1'b0, BASE + 32'h0C, 32'h0, 4'h0, at, n, rd);
        check(rd == pat(3), "R1", "word after reset-aborted write", rd, pat(3));

        // let two frames pass, then check one frame with host reads in flight (R9)
        repeat (2 * HT * VT) @(negedge clk);
        pix_chk = 1;
        for (int i = 0; i < NW; i++) begin
            xfer(1'b0, BASE + 32'(i * 4), 32'h0, 4'h0, at, n, rd);
            check(at == 2 && n == 1 && rd == pat(i), "R9",
                  $sformatf("read word %0d during scan", i), rd, pat(i));
        end
        repeat (HT * VT) @(negedge clk);
        pix_chk = 0;
        check(act_bad == 0 && act_seen >= H * V, "R7", "visible pixel mismatches",
              32'(act_bad), 32'h0);
        check(blk_bad == 0 && blk_seen > 0, "R8", "blanking pixel mismatches",
              32'(blk_bad), 32'h0);
        summary();
    end
endmodule